// File: doc/BRIEF.md
# RTC Update Cycle Sequencer

This block produces the once-per-second update cycle of a real-time clock. A one-clock second pulse requests an update. The block then raises an update-in-progress flag and keeps the time registers untouched for a guard interval. This gives host software a known safe window after it reads the flag as low. When the guard interval ends, the block emits a one-clock advance strobe that steps the calendar counters. It keeps the flag high through the update window that follows. It then drops the flag and emits a one-clock update-ended event, which an interrupt-flag block can latch.

All durations are counted in timebase ticks. A timebase tick is a one-clock enable from a free-running divider. With the default parameters and one tick per microsecond, the guard lasts 244 us, the update window lasts 1984 us, and the flag stays high for 2228 us in total. A hold input, driven by the clock-set bit of the control register, blocks update cycles while software loads new time values. A second pulse that arrives while hold is set is discarded. The block carries no data, so all of its pins are plain control and status levels or pulses, with no handshake.

Top module: `rtc_upd_seq`

## Requirements
- R1: While reset is asserted and in the first clock after reset, `uip_o`, `advance_o` and `upd_end_o` are all 0.
- R2: A `sec_tick_i` pulse sampled while `uip_o` is 0 and `set_hold_i` is 0 drives `uip_o` to 1 in the next clock.
- R3: `advance_o` is a single-clock pulse. It is asserted in the clock after the GUARD_TICKS-th timebase tick counted from the rise of `uip_o` (244 us with the defaults), and `uip_o` is 1 both throughout the guard and in the strobe clock.
- R4: After the strobe, `uip_o` stays 1 for UPD_TICKS further timebase ticks (1984 us). In total it is high for GUARD_TICKS+UPD_TICKS ticks (2228 us), and then it returns to 0.
- R5: `upd_end_o` is a single-clock pulse in the first clock in which `uip_o` is 0 after a completed cycle. Each completed cycle produces exactly one such pulse.
- R6: A `sec_tick_i` pulse sampled while `set_hold_i` is 1 is discarded. No `uip_o`, `advance_o` or `upd_end_o` follows, including after `set_hold_i` later returns to 0.
- R7: If `set_hold_i` is 1 during the guard interval, `uip_o` falls in the next clock and that cycle produces neither `advance_o` nor `upd_end_o`.
- R8: If `set_hold_i` rises after `advance_o`, the update window still runs for its full length and `upd_end_o` is still produced.
- R9: A `sec_tick_i` pulse that arrives while `uip_o` is 1 is ignored and does not start a second cycle.
- R10: Only clocks with `tb_tick_i` high advance the guard and update timers. Clocks without a tick stretch the windows in clock cycles but leave their lengths in ticks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick_i | input | 1 | One-clock pulse per second, requests an update |
| tb_tick_i | input | 1 | One-clock timebase enable, one per timebase period |
| set_hold_i | input | 1 | Clock-set hold, 1 blocks and aborts update cycles |
| uip_o | output | 1 | Update-in-progress status flag |
| advance_o | output | 1 | One-clock strobe that steps the calendar counters |
| upd_end_o | output | 1 | One-clock update-ended event |

## Verification
The assertions assume that `sec_tick_i` and `tb_tick_i` are already clean single-clock enables in the block's clock domain. They also assume that `set_hold_i` changes only on clock edges. The duration checks rely on the timebase ticks that occur while `uip_o` is high being the only source of time. The stimulus drives all three inputs as synchronous levels from the bench, away from the clock edge. It varies the tick density from one tick every clock to one tick every few clocks, and it places second pulses and hold windows at random points relative to the guard and update phases.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  // Phase of the update cycle.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GUARD = 2'd1,
    PH_UPD   = 2'd2
  } upd_phase_e;

  // Counter width able to hold values 0..n.
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rtc_upd_timer.sv
// Window timer: counts timebase ticks and flags the tick that completes
// the currently selected window length.
module rtc_upd_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  // Fires on the tick that would make the count equal the limit.
  assign expire = tick && (cnt_q == (limit - CW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/rtc_upd_ctrl.sv
// Phase controller: idle -> guard -> update window -> idle.
module rtc_upd_ctrl
  import rtc_upd_pkg::*;
#(
  parameter int GUARD_TICKS = 244,
  parameter int UPD_TICKS   = 1984,
  parameter int CW          = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic          hold,
  input  logic          expire,
  output logic          tmr_clr,
  output logic [CW-1:0] tmr_limit,
  output logic          uip,
  output logic          advance,
  output logic          upd_end
);

  localparam logic [CW-1:0] GuardLim = CW'(GUARD_TICKS);
  localparam logic [CW-1:0] UpdLim   = CW'(UPD_TICKS);

  upd_phase_e ph_q, ph_d;
  logic       adv_d, end_d;

  // Timer stays cleared while idle and restarts at every phase change.
  assign tmr_clr   = (ph_q == PH_IDLE) || expire || ((ph_q == PH_GUARD) && hold);
  assign tmr_limit = (ph_q == PH_GUARD) ? GuardLim : UpdLim;

  always_comb begin
    ph_d  = ph_q;
    adv_d = 1'b0;
    end_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        // A second that arrives under hold is dropped, not queued.
        if (sec_tick && !hold) ph_d = PH_GUARD;
      end
      PH_GUARD: begin
        if (hold) begin
          ph_d = PH_IDLE;              // abort before the registers are touched
        end else if (expire) begin
          ph_d  = PH_UPD;
          adv_d = 1'b1;
        end
      end
      PH_UPD: begin
        // Hold no longer matters: the calendar has already been stepped.
        if (expire) begin
          ph_d  = PH_IDLE;
          end_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      uip     <= 1'b0;
      advance <= 1'b0;
      upd_end <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      uip     <= (ph_d != PH_IDLE);
      advance <= adv_d;
      upd_end <= end_d;
    end
  end

endmodule

// File: rtl/rtc_upd_seq.sv
// RTC update cycle sequencer, top level.
module rtc_upd_seq
  import rtc_upd_pkg::*;
#(
  parameter int GUARD_TICKS = 244,
  parameter int UPD_TICKS   = 1984
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick_i,
  input  logic tb_tick_i,
  input  logic set_hold_i,
  output logic uip_o,
  output logic advance_o,
  output logic upd_end_o
);

  localparam int MaxTicks = (GUARD_TICKS > UPD_TICKS) ? GUARD_TICKS : UPD_TICKS;
  localparam int CW       = cnt_width(MaxTicks);

  logic          tmr_clr;
  logic          tmr_exp;
  logic [CW-1:0] tmr_lim;

  rtc_upd_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_clr),
    .tick   (tb_tick_i),
    .limit  (tmr_lim),
    .expire (tmr_exp)
  );

  rtc_upd_ctrl #(
    .GUARD_TICKS (GUARD_TICKS),
    .UPD_TICKS   (UPD_TICKS),
    .CW          (CW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick_i),
    .hold      (set_hold_i),
    .expire    (tmr_exp),
    .tmr_clr   (tmr_clr),
    .tmr_limit (tmr_lim),
    .uip       (uip_o),
    .advance   (advance_o),
    .upd_end   (upd_end_o)
  );

endmodule

// File: rtl/rtc_upd_chk.sv
// Property checker for rtc_upd_seq, attached with bind below.
module rtc_upd_chk #(
  parameter int GUARD_TICKS = 244,
  parameter int UPD_TICKS   = 1984
) (
  input logic clk,
  input logic rst_n,
  input logic sec_tick_i,
  input logic tb_tick_i,
  input logic set_hold_i,
  input logic uip_o,
  input logic advance_o,
  input logic upd_end_o
);

  localparam int TotTicks = GUARD_TICKS + UPD_TICKS;
  localparam int TW       = $clog2(TotTicks + 2);

  // Ticks seen while the flag has been high (window measured with a counter).
  logic [TW-1:0] hi_ticks;
  always_ff @(posedge clk) begin
    if (!rst_n)         hi_ticks <= '0;
    else if (!uip_o)    hi_ticks <= '0;
    else if (tb_tick_i) hi_ticks <= hi_ticks + TW'(1);
  end

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick_i && !set_hold_i && !uip_o) |=> uip_o);

  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hold_i && !uip_o) |=> !uip_o);

  a_r3_adv_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    advance_o |-> uip_o);

  a_r3_adv_single: assert property (@(posedge clk) disable iff (!rst_n)
    advance_o |=> !advance_o);

  a_r3_guard_len: assert property (@(posedge clk) disable iff (!rst_n)
    advance_o |-> (hi_ticks == TW'(GUARD_TICKS)));

  a_r4_total_len: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end_o |-> (hi_ticks == TW'(TotTicks)));

  a_r5_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end_o |-> (!uip_o && $past(uip_o)));

  a_r7_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(uip_o) && !upd_end_o) |-> $past(set_hold_i));

  a_r10_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (uip_o && !tb_tick_i && !set_hold_i) |=> !upd_end_o && !advance_o);

endmodule

bind rtc_upd_seq rtc_upd_chk #(
  .GUARD_TICKS (GUARD_TICKS),
  .UPD_TICKS   (UPD_TICKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick_i (sec_tick_i),
  .tb_tick_i  (tb_tick_i),
  .set_hold_i (set_hold_i),
  .uip_o      (uip_o),
  .advance_o  (advance_o),
  .upd_end_o  (upd_end_o)
);

// File: tb/sim_rtc_upd_seq.sv
module sim_rtc_upd_seq;

  // One timebase tick per microsecond in this bench.
  localparam int US_PER_TICK = 1;
  localparam int GUARD_US    = 244;
  localparam int UPD_US      = 1984;
  localparam int TOTAL_US    = 2228;
  localparam int G           = GUARD_US / US_PER_TICK;
  localparam int U           = UPD_US / US_PER_TICK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec = 1'b0;
  logic tbt = 1'b0;
  logic hold = 1'b0;
  logic uip, adv, upd_end;

  always #10 clk = ~clk;   // 20-unit period, 50 MHz

  rtc_upd_seq #(.GUARD_TICKS(G), .UPD_TICKS(U)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick_i (sec),
    .tb_tick_i  (tbt),
    .set_hold_i (hold),
    .uip_o      (uip),
    .advance_o  (adv),
    .upd_end_o  (upd_end)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  // Reference model state (from the requirements).
  int mst = 0;   // 0 idle, 1 guard, 2 update
  int mc  = 0;
  bit e_uip, e_adv, e_end;

  // Monitor.
  int tk = 0, n_rise = 0, n_adv = 0, n_end = 0, adv_tk = -1, end_tk = -1;

  function automatic int us_to_ticks(input int us);
    return us / US_PER_TICK;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  // Apply one clock of inputs (called at a negedge), advance model, compare.
  task automatic step(input bit p, input bit s, input bit t);
    bit was;
    was = uip;
    sec = p; hold = s; tbt = t;
    e_adv = 1'b0; e_end = 1'b0;
    case (mst)
      0: if (p && !s) begin mst = 1; mc = 0; end
      1: if (s) mst = 0;
         else if (t) begin
           mc++;
           if (mc == G) begin mst = 2; mc = 0; e_adv = 1'b1; end
         end
      default: if (t) begin
           mc++;
           if (mc == U) begin mst = 0; e_end = 1'b1; end
         end
    endcase
    e_uip = (mst != 0);
    @(negedge clk);
    if (was && t) tk++;
    if (!was && uip) begin tk = 0; n_rise++; end
    if (adv) begin n_adv++; adv_tk = tk; end
    if (upd_end) begin n_end++; end_tk = tk; end
    n_vec++;
    if (uip !== e_uip || adv !== e_adv || upd_end !== e_end) begin
      n_bad++;
      if (uip !== e_uip) $display("FAIL R4 uip act=%0b exp=%0b", uip, e_uip);
      if (adv !== e_adv) $display("FAIL R3 advance act=%0b exp=%0b", adv, e_adv);
      if (upd_end !== e_end) $display("FAIL R5 upd_end act=%0b exp=%0b", upd_end, e_end);
    end
  endtask

  task automatic run_to_end(input int max_steps, input bit s, input int dens);
    int e0;
    e0 = n_end;
    for (int i = 0; i < max_steps; i++) begin
      step(1'b0, s, ($urandom_range(0, dens - 1) == 0));
      if (n_end != e0) break;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(3800000);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int r0, a0, d0;
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(uip == 1'b0 && adv == 1'b0 && upd_end == 1'b0, "R1 reset outputs",
        {uip, adv, upd_end}, 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    chk({uip, adv, upd_end} == 3'b000, "R1 first clock", {uip, adv, upd_end}, 0);

    // R2..R5: nominal cycle, one tick per clock
    step(1'b1, 1'b0, 1'b1);
    chk(uip == 1'b1, "R2 uip rises next clock", uip, 1);
    a0 = n_adv; d0 = n_end;
    run_to_end(3000, 1'b0, 1);
    chk(n_adv == a0 + 1, "R3 one advance", n_adv - a0, 1);
    chk(adv_tk == us_to_ticks(GUARD_US), "R3 guard ticks", adv_tk, us_to_ticks(GUARD_US));
    chk(end_tk == us_to_ticks(TOTAL_US), "R4 uip high ticks", end_tk, us_to_ticks(TOTAL_US));
    chk(uip == 1'b0 && upd_end == 1'b1, "R5 end pulse as uip falls", {uip, upd_end}, 1);
    step(1'b0, 1'b0, 1'b1);
    chk(upd_end == 1'b0 && n_end == d0 + 1, "R5 single end pulse", n_end - d0, 1);

    // R6: second under hold is dropped, release does not replay it
    r0 = n_rise; a0 = n_adv; d0 = n_end;
    step(1'b1, 1'b1, 1'b1);
    repeat (50) step(1'b0, 1'b1, 1'b1);
    repeat (3000) step(1'b0, 1'b0, 1'b1);
    chk(n_rise == r0, "R6 no uip under hold", n_rise - r0, 0);
    chk(n_adv == a0 && n_end == d0, "R6 no advance or end", (n_adv - a0) + (n_end - d0), 0);

    // R7: hold during guard aborts
    a0 = n_adv; d0 = n_end;
    step(1'b1, 1'b0, 1'b1);
    repeat (100) step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    chk(uip == 1'b0, "R7 uip falls on hold", uip, 0);
    repeat (3000) step(1'b0, 1'b1, 1'b1);
    chk(n_adv == a0 && n_end == d0, "R7 aborted cycle silent", (n_adv - a0) + (n_end - d0), 0);
    repeat (5) step(1'b0, 1'b0, 1'b1);

    // R8: hold after the advance does not stop the update window
    a0 = n_adv; d0 = n_end;
    step(1'b1, 1'b0, 1'b1);
    repeat (600) step(1'b0, 1'b0, 1'b1);
    chk(n_adv == a0 + 1, "R8 advance before hold", n_adv - a0, 1);
    run_to_end(3000, 1'b1, 1);
    chk(n_end == d0 + 1, "R8 end despite hold", n_end - d0, 1);
    chk(end_tk == us_to_ticks(TOTAL_US), "R8 full window", end_tk, us_to_ticks(TOTAL_US));
    repeat (5) step(1'b0, 1'b0, 1'b1);

    // R9: second during a running cycle is ignored
    r0 = n_rise; a0 = n_adv; d0 = n_end;
    step(1'b1, 1'b0, 1'b1);
    repeat (1000) step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    repeat (4000) step(1'b0, 1'b0, 1'b1);
    chk(n_rise == r0 + 1 && n_adv == a0 + 1 && n_end == d0 + 1, "R9 one cycle only",
        n_adv - a0, 1);

    // R10: sparse timebase stretches clocks, not ticks
    step(1'b1, 1'b0, 1'b1);
    run_to_end(12000, 1'b0, 3);
    chk(adv_tk == G, "R10 guard ticks sparse", adv_tk, G);
    chk(end_tk == G + U, "R10 total ticks sparse", end_tk, G + U);
    repeat (5) step(1'b0, 1'b0, 1'b1);

    // Random episodes against the model (R2..R10 interleavings)
    for (int ep = 0; ep < 12; ep++) begin
      int dens, len, p_at, h_from, h_to, p2_at;
      dens   = $urandom_range(1, 3);
      len    = 2600 * dens + 400;
      p_at   = $urandom_range(0, 200);
      p2_at  = $urandom_range(300, len - 1);
      h_from = ($urandom_range(0, 2) == 0) ? $urandom_range(0, len - 1) : len;
      h_to   = h_from + $urandom_range(1, 1500);
      for (int c = 0; c < len; c++) begin
        step((c == p_at) || (c == p2_at), (c >= h_from) && (c < h_to),
             ($urandom_range(0, dens - 1) == 0));
      end
      while (mst != 0) step(1'b0, 1'b0, 1'b1);
      chk(uip == 1'b0, "R4 episode settles idle", uip, 0);
    end

    done_flag = 1'b1;
    summary();
    $finish;
  end

endmodule